// File: doc/BRIEF.md
# ADC Conversion and Power Sequencer

This block runs the analog side of an eight-channel, 8-bit successive-approximation converter. It accepts one command byte at a time on a valid/ready stream. From that byte it sets the channel-multiplexer selection, the measurement-type flag, the internal-reference enable and the converter enable. When a command changes the reference or converter power state, the block waits a settling interval before it starts a conversion. The interval length is picked by the current bus-speed class from three programmable constants. The conversion engine is modelled as a start/busy/done core that takes a fixed number of cycles. It samples the digital stand-in of the analog input when it starts.

Results leave on a second valid/ready stream. Back-pressure works as follows. A result stays valid, and its data stays fixed, until the consumer raises `res_ready`. The block takes no new command while a result is pending, while it is settling or while it is converting. As a result, `cmd_ready` is high only when the block is idle and its output is empty. A command whose power field turns the converter off only changes power. It produces no result.

Top module: `conv_power_seq`

## Requirements
- R1: After reset, `ref_en`, `conv_en`, `busy` and `res_valid` are 0, and `cmd_ready` is 1.
- R2: On command acceptance, bit 7 of the byte sets `single_ended` (1 = single-ended, 0 = differential) and bits 6:4 set `mux_sel`. Bits 1:0 have no effect. Both outputs hold until the next accepted command.
- R3: Bits 3:2 set the power targets on acceptance. 01 gives reference off and converter on, 10 gives reference on and converter off, 11 gives both on, and 00 gives both on for the conversion only.
- R4: If the targets differ from the present `ref_en`/`conv_en`, the result is valid K+1+C cycles after acceptance, where C = `CONV_CYCLES`. K is `settle_std` for `speed_mode` 00, `settle_fast` for 01 and `settle_hs` for 1x.
- R5: If the targets match the present enables and a conversion is requested, the result is valid C cycles after acceptance.
- R6: In power mode 00, `ref_en` and `conv_en` are both 0 once the result is valid. The next command therefore settles again.
- R7: In power mode 10, no conversion starts: `busy` and `res_valid` stay 0 and `res_data` keeps its previous value.
- R8: `busy` is high for exactly C cycles per conversion and falls as `res_valid` rises. `res_data` equals `samp_in` as held during the conversion.
- R9: While `res_valid` is high and `res_ready` is low, `res_valid` and `res_data` hold. `cmd_ready` is 0 while a result is pending or the block is not idle.
- R10: While `busy` is high, `conv_en` is 1 and neither enable changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_data | input | 8 | Command byte |
| speed_mode | input | 2 | Bus-speed class: 00 standard, 01 fast, 1x high |
| settle_std | input | CNT_W | Settling cycles, standard speed |
| settle_fast | input | CNT_W | Settling cycles, fast speed |
| settle_hs | input | CNT_W | Settling cycles, high speed |
| samp_in | input | DATA_W | Digital stand-in for the analog input |
| mux_sel | output | 3 | Channel or channel-pair select |
| single_ended | output | 1 | 1 = single-ended, 0 = differential |
| ref_en | output | 1 | Internal reference enable |
| conv_en | output | 1 | Converter power enable |
| busy | output | 1 | Conversion in progress |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | DATA_W | Conversion result |

## Verification
The command sequence walks the power field through every transition. It covers an off-to-on start, a repeat with unchanged power, a reference-off switch, converter-off commands with and without a state change, and back-to-back automatic power-down commands. Measuring latency from acceptance to result separates the settled path from the direct path, and shows which of the three constants was used for each speed class. Converter-off commands tell a power-only update apart from a real conversion, because they must leave the previous result in place. Each result is held against `res_ready` for several cycles to exercise back-pressure, and a final reset shows that the reference returns to off.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    PWR_AUTO      = 2'b00,
    PWR_CONV_ONLY = 2'b01,
    PWR_REF_ONLY  = 2'b10,
    PWR_ALL       = 2'b11
  } pwr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_CONV   = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic             single;
    logic [SEL_W-1:0] sel;
    pwr_mode_e        pwr;
  } cmd_t;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import conv_seq_pkg::*;
(
  input  logic [7:0] byte_in,
  output cmd_t       cmd,
  output logic       want_ref,
  output logic       want_conv
);
  logic [5:0] used;
  assign used = byte_in[7:2];

  always_comb begin
    cmd.single = used[5];
    cmd.sel    = used[4:2];
    cmd.pwr    = pwr_mode_e'(used[1:0]);
    want_ref   = (cmd.pwr != PWR_CONV_ONLY);
    want_conv  = (cmd.pwr != PWR_REF_ONLY);
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [1:0]       speed_mode,
  input  logic [CNT_W-1:0] k_std,
  input  logic [CNT_W-1:0] k_fast,
  input  logic [CNT_W-1:0] k_hs,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;

  always_comb begin
    unique case (speed_mode)
      2'b00:   reload = k_std;
      2'b01:   reload = k_fast;
      default: reload = k_hs;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= reload;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sar_model.sv
module sar_model #(
  parameter int CYCLES = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] samp,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] data
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      data  <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= LAST;
      data  <= samp;
    end else if (done) begin
      busy  <= 1'b0;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/conv_power_seq.sv
module conv_power_seq
  import conv_seq_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 8,
  parameter int CONV_CYCLES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_data,
  input  logic [1:0]        speed_mode,
  input  logic [CNT_W-1:0]  settle_std,
  input  logic [CNT_W-1:0]  settle_fast,
  input  logic [CNT_W-1:0]  settle_hs,
  input  logic [DATA_W-1:0] samp_in,
  output logic [SEL_W-1:0]  mux_sel,
  output logic              single_ended,
  output logic              ref_en,
  output logic              conv_en,
  output logic              busy,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data
);
  seq_state_e state_q, state_d;
  cmd_t       dec;
  logic       want_ref, want_conv, accept, change, expired;
  logic       sar_start, sar_done;
  logic [DATA_W-1:0] sar_data;
  pwr_mode_e  pwr_q;

  cmd_decode u_dec (
    .byte_in(cmd_data), .cmd(dec), .want_ref(want_ref), .want_conv(want_conv)
  );

  assign cmd_ready = (state_q == ST_IDLE) && !res_valid;
  assign accept    = cmd_valid && cmd_ready;
  assign change    = (want_ref != ref_en) || (want_conv != conv_en);

  settle_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(accept && change),
    .run(state_q == ST_SETTLE), .speed_mode(speed_mode),
    .k_std(settle_std), .k_fast(settle_fast), .k_hs(settle_hs),
    .expired(expired)
  );

  assign sar_start = (accept && !change && want_conv) ||
                     (state_q == ST_SETTLE && expired && conv_en);

  sar_model #(.CYCLES(CONV_CYCLES), .DATA_W(DATA_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .start(sar_start), .samp(samp_in),
    .busy(busy), .done(sar_done), .data(sar_data)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (accept) begin
          if (change)         state_d = ST_SETTLE;
          else if (want_conv) state_d = ST_CONV;
        end
      ST_SETTLE:
        if (expired) state_d = conv_en ? ST_CONV : ST_IDLE;
      ST_CONV:
        if (sar_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      ref_en       <= 1'b0;
      conv_en      <= 1'b0;
      pwr_q        <= PWR_AUTO;
      mux_sel      <= '0;
      single_ended <= 1'b0;
      res_valid    <= 1'b0;
      res_data     <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        ref_en       <= want_ref;
        conv_en      <= want_conv;
        pwr_q        <= dec.pwr;
        mux_sel      <= dec.sel;
        single_ended <= dec.single;
      end else if (sar_done && pwr_q == PWR_AUTO) begin
        ref_en  <= 1'b0;
        conv_en <= 1'b0;
      end
      if (sar_done) begin
        res_valid <= 1'b1;
        res_data  <= sar_data;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/conv_power_seq_chk.sv
module conv_power_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              ref_en,
  input logic              conv_en,
  input logic              busy,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data
);
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!res_valid && !busy));

  assert_busy_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> res_valid);

  assert_conv_powered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> conv_en);

  assert_power_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable({ref_en, conv_en}));

  assert_no_conv_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |-> !busy);
endmodule

bind conv_power_seq conv_power_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .ref_en(ref_en),
  .conv_en(conv_en), .busy(busy), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data)
);

// File: tb/test_conv_power_seq.sv
module test_conv_power_seq;
  localparam int CNT_W = 16;
  localparam int DW    = 8;
  localparam int C     = 10;
  localparam int KSTD  = 12;
  localparam int KFAST = 6;
  localparam int KHS   = 3;

  typedef struct packed {
    logic [1:0] spd;
    logic [7:0] cmd;
    logic [7:0] samp;
    logic       settle;
    logic       conv;
    logic       ref_run;
    logic       ref_after;
    logic       conv_after;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 8'hDC, 8'h3A, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    '{2'b01, 8'h2F, 8'hC5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    '{2'b01, 8'hF4, 8'h81, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{2'b10, 8'h08, 8'h11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'b10, 8'hB0, 8'h5F, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{2'b00, 8'h60, 8'hA7, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{2'b11, 8'h98, 8'h22, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'b00, 8'hC8, 8'h33, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  logic clk = 0, rst_n = 0, cmd_valid = 0, res_ready = 0;
  logic [7:0] cmd_data = '0;
  logic [1:0] speed_mode = '0;
  logic [DW-1:0] samp_in = '0;
  logic cmd_ready, single_ended, ref_en, conv_en, busy, res_valid;
  logic [2:0] mux_sel;
  logic [DW-1:0] res_data;
  int compared = 0, mismatched = 0;
  logic [7:0] last_res = '0;

  always #10 clk = ~clk;

  conv_power_seq #(.CNT_W(CNT_W), .DATA_W(DW), .CONV_CYCLES(C)) i_conv_power_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .speed_mode(speed_mode),
    .settle_std(CNT_W'(KSTD)), .settle_fast(CNT_W'(KFAST)), .settle_hs(CNT_W'(KHS)),
    .samp_in(samp_in), .mux_sel(mux_sel), .single_ended(single_ended),
    .ref_en(ref_en), .conv_en(conv_en), .busy(busy), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int settle_of(input logic [1:0] s);
    case (s)
      2'b00:   return KSTD;
      2'b01:   return KFAST;
      default: return KHS;
    endcase
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 ref_en", ref_en, 0);
    check("R1 conv_en", conv_en, 0);
    check("R1 busy", busy, 0);
    check("R1 res_valid", res_valid, 0);
    @(negedge clk); rst_n = 1;
    step();
    check("R1 cmd_ready", cmd_ready, 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int n, busy_cnt, exp_lat;
      bit seen_busy, seen_valid, ref_ok;
      v = VEC[i];
      @(negedge clk);
      check("R9 ready before cmd", cmd_ready, 1);
      speed_mode = v.spd; samp_in = v.samp; cmd_data = v.cmd; cmd_valid = 1;
      step();
      @(negedge clk); cmd_valid = 0; cmd_data = 8'h00;
      // R2 decode
      check("R2 mux_sel", mux_sel, int'(v.cmd[6:4]));
      check("R2 single_ended", single_ended, int'(v.cmd[7]));
      if (v.conv) begin
        exp_lat = (v.settle ? settle_of(v.spd) + 1 : 0) + C;
        n = 1; busy_cnt = 0; ref_ok = 1; seen_busy = 0;
        while (!res_valid && n < 200) begin
          if (busy) begin
            busy_cnt++;
            if (ref_en != v.ref_run || !conv_en) ref_ok = 0;
          end
          if (cmd_ready) ref_ok = 0;
          step(); n++;
        end
        // R4 / R5 latency
        check(v.settle ? "R4 settled latency" : "R5 direct latency", n - 1, exp_lat);
        check("R8 busy cycles", busy_cnt, C);
        check("R8 busy low at result", busy, 0);
        check("R3 power during conversion / R9 ready low", ref_ok, 1);
        check("R8 result data", res_data, v.samp);
        check("R6 ref_en after", ref_en, v.ref_after);
        check("R6 conv_en after", conv_en, v.conv_after);
        // R9 back-pressure
        repeat (3) step();
        check("R9 valid held", res_valid, 1);
        check("R9 data held", res_data, v.samp);
        check("R9 cmd_ready low", cmd_ready, 0);
        @(negedge clk); res_ready = 1;
        step();
        @(negedge clk); res_ready = 0;
        check("R9 valid cleared", res_valid, 0);
        last_res = v.samp;
      end else begin
        seen_busy = 0; seen_valid = 0;
        for (int k = 0; k < KSTD + C + 5; k++) begin
          if (busy) seen_busy = 1;
          if (res_valid) seen_valid = 1;
          step();
        end
        check("R7 no busy", seen_busy, 0);
        check("R7 no result", seen_valid, 0);
        check("R7 result held", res_data, last_res);
        check("R3 ref_en", ref_en, v.ref_after);
        check("R3 conv_en", conv_en, v.conv_after);
        check("R9 ready after power-only", cmd_ready, 1);
      end
    end

    // R1 reset returns reference off
    @(negedge clk); rst_n = 0;
    step();
    check("R1 ref_en after reset", ref_en, 0);
    check("R1 res_data after reset", res_data, 0);
    @(negedge clk); rst_n = 1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule